// File: doc/BRIEF.md
# UART FIFO Level Register Interface

This block is the register-access front end that lets host software manage the FIFO levels of a UART. Over a simple read/write bus it holds a separate trigger level for the transmit FIFO and for the receive FIFO. It also reports how many characters each FIFO currently holds. The occupancy counts come in as inputs from the FIFOs, and the two trigger levels go out to whatever logic compares against them.

A protected register page opens only while the line-control byte holds a fixed key value. Inside that page, the level address does two jobs. A write programs a trigger level and a read returns a character count. A direction bit in the feature byte selects whether the transmitter or the receiver is meant.

A swap bit in the feature byte turns the scratch-pad address into a count readback port. In that mode, writes to the scratch-pad address made while the page is open go to a small mode register. That register chooses the receive count, the transmit count, or an alternating mode. In the alternating mode, successive reads return the receive count and the transmit count in turn, with the direction carried in bit 7.

Top module: `uart_fifo_lvl_regs`

## Requirements
- R1: After reset the line-control byte, feature byte, scratch byte and mode register are 0, both trigger outputs are 0, and the alternating mode starts on the receive side.
- R2: While the line-control byte is not 0xBF, writes to address 0 and address 1 have no effect, and reads of them return 0.
- R3: With the page open, a write to address 0 sets the transmit trigger when feature bit 7 is 1 and the receive trigger when it is 0. Values above 128 are stored as 128.
- R4: With the page open, a read of address 0 returns the full transmit count when feature bit 7 is 1 and the full receive count when it is 0.
- R5: While feature bit 6 is 0, address 7 is a plain 8-bit read/write storage byte, whatever the line-control byte holds.
- R6: While feature bit 6 is 1, a read of address 7 returns a count and leaves the stored scratch byte intact. Mode bit 0 = 0 selects the receive count and mode bit 0 = 1 selects the transmit count.
- R7: The mode register (wdata bits 1:0) is written only by a write to address 7 while the page is open and feature bit 6 is 1. Other writes leave it unchanged.
- R8: With feature bit 6 = 1 and mode bits 1:0 = 11, a read of address 7 returns {dir, count saturated at 127}, where dir = 0 means receive and dir = 1 means transmit. The first read returns the receive side, and dir flips after each read strobe at address 7.
- R9: Whenever the alternating mode is not active, the next alternating read is reset to the receive side.
- R10: Address 3 holds the line-control byte. It can be read and written at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address (combinational) |
| tx_cnt | input | CW | Transmit FIFO occupancy |
| rx_cnt | input | CW | Receive FIFO occupancy |
| tx_trig | output | CW | Programmed transmit trigger level |
| rx_trig | output | CW | Programmed receive trigger level |

## Verification
The bench targets the page gate and checks it at the ports. A design that let writes through with the page closed would change a trigger level or the feature byte, and the bench reads that change back. The bench also programs values of 128 and above, where a missing clamp would show a trigger of 255. It reads a full 128-entry FIFO in alternating mode, where a missing saturation would set bit 7 and corrupt the direction flag. It leaves and re-enters the alternating mode while the toggle points at transmit: a design that kept the stale toggle would return transmit first.

// File: rtl/uart_fifo_lvl_regs.sv
module uart_fifo_lvl_regs #(
  parameter int          DEPTH    = 128,
  parameter logic [7:0]  PAGE_KEY = 8'hBF,
  parameter logic [2:0]  A_LVL    = 3'd0,
  parameter logic [2:0]  A_FEAT   = 3'd1,
  parameter logic [2:0]  A_LINE   = 3'd3,
  parameter logic [2:0]  A_SPAD   = 3'd7,
  localparam int         CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic [CW-1:0] tx_cnt,
  input  logic [CW-1:0] rx_cnt,
  output logic [CW-1:0] tx_trig,
  output logic [CW-1:0] rx_trig
);

  logic [7:0] lcr_q, feat_q, spad_q;
  logic [1:0] emode_q;
  logic       alt_dir_q;

  wire page   = (lcr_q == PAGE_KEY);
  wire dir_tx = feat_q[7];
  wire swap   = feat_q[6];
  wire alt    = swap && (emode_q == 2'b11);

  wire [CW-1:0] lvl_in  = (int'(wdata) > DEPTH) ? CW'(DEPTH) : CW'(wdata);
  wire [CW-1:0] dir_cnt = dir_tx ? tx_cnt : rx_cnt;
  wire [CW-1:0] sel_cnt = emode_q[0] ? tx_cnt : rx_cnt;
  wire [CW-1:0] alt_cnt = alt_dir_q ? tx_cnt : rx_cnt;
  wire [6:0]    alt_sat = (int'(alt_cnt) > 127) ? 7'd127 : 7'(alt_cnt);

  wire wr_lvl  = wr_en && page && addr == A_LVL;
  wire wr_feat = wr_en && page && addr == A_FEAT;
  wire wr_line = wr_en && addr == A_LINE;
  wire wr_spad = wr_en && addr == A_SPAD && !swap;
  wire wr_emod = wr_en && addr == A_SPAD && swap && page;
  wire rd_alt  = rd_en && addr == A_SPAD && alt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q     <= '0;
      feat_q    <= '0;
      spad_q    <= '0;
      emode_q   <= '0;
      alt_dir_q <= 1'b0;
      tx_trig   <= '0;
      rx_trig   <= '0;
    end else begin
      if (wr_line) lcr_q <= wdata;
      if (wr_feat) feat_q <= wdata;
      if (wr_spad) spad_q <= wdata;
      if (wr_emod) emode_q <= wdata[1:0];
      if (wr_lvl &&  dir_tx) tx_trig <= lvl_in;
      if (wr_lvl && !dir_tx) rx_trig <= lvl_in;
      if (!alt)        alt_dir_q <= 1'b0;
      else if (rd_alt) alt_dir_q <= ~alt_dir_q;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_LINE: rdata = lcr_q;
      A_FEAT: rdata = page ? feat_q : 8'h00;
      A_LVL:  rdata = page ? 8'(dir_cnt) : 8'h00;
      A_SPAD: rdata = !swap ? spad_q : alt ? {alt_dir_q, alt_sat} : 8'(sel_cnt);
      default: rdata = '0;
    endcase
  end

endmodule

module uart_fifo_lvl_regs_chk #(
  parameter int         DEPTH  = 128,
  parameter logic [7:0] KEY    = 8'hBF,
  parameter logic [2:0] A_LVL  = 3'd0,
  parameter logic [2:0] A_SPAD = 3'd7,
  parameter int         CW     = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    addr,
  input logic          wr_en,
  input logic          rd_en,
  input logic [7:0]    wdata,
  input logic [CW-1:0] tx_trig,
  input logic [CW-1:0] rx_trig,
  input logic [7:0]    lcr_q,
  input logic [7:0]    feat_q,
  input logic [7:0]    spad_q,
  input logic [1:0]    emode_q,
  input logic          alt_dir_q
);
  // R3
  trig_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tx_trig) <= DEPTH && int'(rx_trig) <= DEPTH);
  // R2
  page_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_LVL && lcr_q != KEY) |=> ($stable(tx_trig) && $stable(rx_trig)));
  // R5
  spad_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SPAD && !feat_q[6]) |=> (spad_q == $past(wdata)));
  // R7
  emode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SPAD && lcr_q != KEY) |=> $stable(emode_q));
  // R8
  alt_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_SPAD && feat_q[6] && emode_q == 2'b11) |=> (alt_dir_q != $past(alt_dir_q)));
  // R9
  alt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(feat_q[6] && emode_q == 2'b11) |=> !alt_dir_q);
endmodule

bind uart_fifo_lvl_regs uart_fifo_lvl_regs_chk #(
  .DEPTH(DEPTH), .KEY(PAGE_KEY), .A_LVL(A_LVL), .A_SPAD(A_SPAD), .CW(CW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .tx_trig(tx_trig), .rx_trig(rx_trig), .lcr_q(lcr_q),
  .feat_q(feat_q), .spad_q(spad_q), .emode_q(emode_q), .alt_dir_q(alt_dir_q)
);

// File: tb/uart_fifo_lvl_regs_tb.sv
`timescale 1ns/1ps
module uart_fifo_lvl_regs_tb_top;
  logic       clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic       wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic [7:0] tx_cnt = 0, rx_cnt = 0, tx_trig, rx_trig;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] last_rd;

  int m_lcr, m_feat, m_spad, m_emode, m_tt, m_rt, m_tog;

  always #4 clk = ~clk;

  uart_fifo_lvl_regs dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .tx_trig(tx_trig), .rx_trig(rx_trig));

  function automatic int model_rd(int a);
    int page, c;
    page = (m_lcr == 'hBF);
    case (a)
      3: return m_lcr;
      1: return page ? m_feat : 0;
      0: return page ? ((m_feat & 'h80) ? tx_cnt : rx_cnt) : 0;
      7: begin
        if (!(m_feat & 'h40)) return m_spad;
        if (m_emode == 3) begin
          c = m_tog ? tx_cnt : rx_cnt;
          if (c > 127) c = 127;
          return m_tog * 128 + c;
        end
        return (m_emode & 1) ? tx_cnt : rx_cnt;
      end
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int a, bit w, bit r, int d, string tag);
    int page, alt;
    @(negedge clk);
    addr = 3'(a); wr_en = w; rd_en = r; wdata = 8'(d);
    #1;
    last_rd = rdata;
    check({tag, " rdata"}, rdata, model_rd(a));
    check({tag, " tx_trig"}, tx_trig, m_tt);
    check({tag, " rx_trig"}, rx_trig, m_rt);
    @(posedge clk);
    page = (m_lcr == 'hBF);
    alt = (m_feat & 'h40) && m_emode == 3;
    if (!alt) m_tog = 0; else if (r && a == 7) m_tog = 1 - m_tog;
    if (w) begin
      if (a == 3) m_lcr = d;
      if (a == 1 && page) m_feat = d;
      if (a == 7 && !(m_feat & 'h40)) m_spad = d;
      if (a == 7 && (m_feat & 'h40) && page) m_emode = d & 3;
      if (a == 0 && page) begin
        if (m_feat & 'h80) m_tt = (d > 128) ? 128 : d;
        else m_rt = (d > 128) ? 128 : d;
      end
    end
  endtask

  task automatic wr(int a, int d, string tag); cyc(a, 1, 0, d, tag); endtask
  task automatic rd_exp(int a, int exp, string tag);
    cyc(a, 0, 1, 0, tag);
    check({tag, " literal"}, last_rd, exp);
  endtask
  task automatic trig_exp(int et, int er, string tag);
    cyc(2, 0, 0, 0, tag);
    check({tag, " tx literal"}, tx_trig, et);
    check({tag, " rx literal"}, rx_trig, er);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_lcr = 0; m_feat = 0; m_spad = 0; m_emode = 0; m_tt = 0; m_rt = 0; m_tog = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    rd_exp(3, 0, "R1 line");
    rd_exp(7, 0, "R1 scratch");
    trig_exp(0, 0, "R1 trig");
    // R10 line byte
    wr(3, 'h03, "R10");
    rd_exp(3, 'h03, "R10 read");
    // R2 gate closed
    wr(0, 'h40, "R2");
    trig_exp(0, 0, "R2 lvl ignored");
    wr(1, 'hC0, "R2");
    rd_exp(1, 0, "R2 feat hidden");
    // R5 scratch
    wr(7, 'h5A, "R5");
    rd_exp(7, 'h5A, "R5 read");
    wr(3, 'hBF, "R10 open");
    rd_exp(1, 0, "R2 feat write ignored");
    // R3 triggers
    wr(1, 'h80, "R3");
    wr(0, 'h20, "R3");
    trig_exp('h20, 0, "R3 tx");
    wr(1, 'h00, "R3");
    wr(0, 'hFF, "R3");
    trig_exp('h20, 128, "R3 clamp");
    wr(0, 128, "R3");
    trig_exp('h20, 128, "R3 max");
    wr(0, 0, "R3");
    trig_exp('h20, 0, "R3 zero");
    // R4 counts
    rx_cnt = 9; tx_cnt = 77;
    rd_exp(0, 9, "R4 rx");
    wr(1, 'h80, "R4");
    rd_exp(0, 77, "R4 tx");
    // R6 swap
    wr(1, 'h40, "R6");
    rd_exp(7, 9, "R6 rx count");
    wr(7, 'h01, "R7 open write");
    rd_exp(7, 77, "R6 tx count");
    wr(1, 'h00, "R6");
    rd_exp(7, 'h5A, "R6 scratch kept");
    // R7 gate closed
    wr(1, 'h40, "R7");
    wr(3, 'h03, "R7");
    wr(7, 'h00, "R7 closed write");
    rd_exp(7, 77, "R7 mode unchanged");
    // R8 alternate
    wr(3, 'hBF, "R8");
    wr(7, 'hC3, "R8");
    rx_cnt = 128; tx_cnt = 5;
    rd_exp(7, 'h7F, "R8 rx first sat");
    rd_exp(7, 'h85, "R8 tx second");
    cyc(7, 0, 0, 0, "R8 no strobe");
    rd_exp(7, 'h7F, "R8 rx third");
    tx_cnt = 128;
    rd_exp(7, 'hFF, "R8 tx sat");
    rd_exp(7, 'h7F, "R8 rx again");
    // R9 leave and re-enter with toggle on tx
    wr(7, 'h01, "R9");
    wr(7, 'h03, "R9");
    rd_exp(7, 'h7F, "R9 rx first");
    wr(1, 'h00, "R5");
    rd_exp(7, 'h5A, "R5 scratch intact");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule